// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level, forward-mapped page table held in memory. Pages and frames are 1 KB. The ten low address bits are the byte offset within the page. The 22-bit page number splits into two parts. The upper 12 bits pick an entry in a first-level directory, which starts at a base address supplied by the caller. The next 10 bits pick an entry in the second-level table that the directory entry points to.

A caller raises a request with an address and an access kind. The walker checks the directory index against a supplied length bound. It then issues at most two word reads through a simple read port. The first read fetches the directory entry and the second fetches the leaf entry. Each read takes an address handshake followed by a response after any latency. The walk ends in one of two one-cycle pulses:

- a completion pulse, which carries the physical address;
- a fault pulse, which carries a code saying which check failed.

Only one walk runs at a time. The base address and the length bound are captured when the request is accepted.

Top module: `pt_walker`

## Requirements
- R1: The first read goes to base + 4 × d, where d is address bits [31:20].
- R2: The second read goes to (directory entry bits [31:10] shifted left 10) + 4 × t, where t is address bits [19:10].
- R3: If d is greater than or equal to the length bound, the walk ends with a fault whose code is 1, and no memory read is issued.
- R4: If the directory entry's valid flag (bit 0) is clear, the walk ends with fault code 2, and no second read is issued.
- R5: If the leaf entry's valid flag (bit 0) is clear, the walk ends with fault code 3.
- R6: A write (kind 1) to a leaf entry whose writable flag (bit 1) is clear faults with code 4. A write to a leaf entry whose writable flag is set completes.
- R7: Execute access, kind 2, is governed by two leaf flags: the executable flag (bit 2) and the execute-only flag (bit 3).
  - An execute access to a leaf entry whose executable flag is clear faults with code 4.
  - When the execute-only flag is set, any access other than execute (read is kind 0 or 3, write is kind 1) faults with code 4.
- R8: On completion, the physical address is leaf entry bits [31:10] followed by the unchanged offset bits [9:0], and the fault code is 0.
- R9: The ready signal falls once a request is accepted and stays low until the done or fault pulse. Each pulse lasts exactly one cycle, the two pulses never coincide, and ready is high in the cycle after a pulse.
- R10: The read address stays valid and stable until the port accepts it. Responses may arrive after any number of cycles, and stalled accepts do not change the result.
- R11: After reset, ready is high, and done, fault and the read request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_vaddr | input | 32 | Logical address |
| req_kind | input | 2 | 0/3 read, 1 write, 2 execute |
| pt_base | input | 32 | Directory base address |
| pt_len | input | 13 | Number of legal directory entries |
| mem_rd_valid | output | 1 | Read address valid |
| mem_rd_ready | input | 1 | Read address accepted |
| mem_rd_addr | output | 32 | Read word address (byte address) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (table entry) |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| paddr | output | 32 | Physical address, valid with done |
| fault_code | output | 3 | 0 none, 1 length, 2 directory invalid, 3 leaf invalid, 4 protection |

## Verification
Most state errors in this walker appear at the port within a few cycles.

- A corrupted captured index or table pointer shows up on the very next read address.
- A wrong stage in the state machine shows up either as a missing or extra read, or as a pulse that comes too early.
- A mixed-up flag decode shows up as the wrong pulse or fault code once the leaf response arrives.

The checks therefore compare every issued read address, the count of reads and the final pulse against values computed from the table contents. They also watch the ready signal through the whole walk.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int P2_W  = 10,
  parameter int PA_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic [1:0]              req_kind,
  input  logic [PA_W-1:0]         pt_base,
  input  logic [VA_W-OFF_W-P2_W:0] pt_len,
  output logic                    mem_rd_valid,
  input  logic                    mem_rd_ready,
  output logic [PA_W-1:0]         mem_rd_addr,
  input  logic                    mem_rsp_valid,
  input  logic [PA_W-1:0]         mem_rsp_data,
  output logic                    done,
  output logic                    fault,
  output logic [PA_W-1:0]         paddr,
  output logic [2:0]              fault_code
);
  localparam int P1_W  = VA_W - OFF_W - P2_W;
  localparam int FRM_W = PA_W - OFF_W;
  localparam logic [2:0] FC_NONE = 3'd0, FC_LEN = 3'd1, FC_DIR = 3'd2,
                         FC_LEAF = 3'd3, FC_PROT = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_OUTER, S_INNER, S_DONE, S_FAULT} st_t;

  st_t              st;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       kind_q;
  logic [PA_W-1:0]  base_q;
  logic [FRM_W-1:0] tbl_q;
  logic             issued;
  logic [PA_W-1:0]  pa_q;
  logic [2:0]       fc_q;

  wire [P1_W-1:0] req_p1 = req_vaddr[VA_W-1 -: P1_W];
  wire [P1_W-1:0] p1     = va_q[VA_W-1 -: P1_W];
  wire [P2_W-1:0] p2     = va_q[OFF_W +: P2_W];

  wire [PA_W-1:0] dir_addr  = base_q + PA_W'({p1, 2'b00});
  wire [PA_W-1:0] leaf_addr = {tbl_q, {OFF_W{1'b0}}} + PA_W'({p2, 2'b00});

  wire e_valid = mem_rsp_data[0];
  wire e_wr    = mem_rsp_data[1];
  wire e_ex    = mem_rsp_data[2];
  wire e_xo    = mem_rsp_data[3];
  wire is_wr   = (kind_q == 2'd1);
  wire is_ex   = (kind_q == 2'd2);
  wire prot_bad = (is_wr && !e_wr) || (is_ex && !e_ex) || (e_xo && !is_ex);

  wire rsp_in = issued && mem_rsp_valid;
  wire rd_hs  = mem_rd_valid && mem_rd_ready;

  assign req_ready    = (st == S_IDLE);
  assign mem_rd_valid = ((st == S_OUTER) || (st == S_INNER)) && !issued;
  assign mem_rd_addr  = (st == S_INNER) ? leaf_addr : dir_addr;
  assign done         = (st == S_DONE);
  assign fault        = (st == S_FAULT);
  assign paddr        = pa_q;
  assign fault_code   = fc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      kind_q <= '0;
      base_q <= '0;
      tbl_q  <= '0;
      issued <= 1'b0;
      pa_q   <= '0;
      fc_q   <= FC_NONE;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          kind_q <= req_kind;
          base_q <= pt_base;
          issued <= 1'b0;
          pa_q   <= '0;
          if ({1'b0, req_p1} >= pt_len) begin
            fc_q <= FC_LEN;
            st   <= S_FAULT;
          end else begin
            fc_q <= FC_NONE;
            st   <= S_OUTER;
          end
        end
        S_OUTER: begin
          if (rd_hs) issued <= 1'b1;
          if (rsp_in) begin
            issued <= 1'b0;
            if (!e_valid) begin
              fc_q <= FC_DIR;
              st   <= S_FAULT;
            end else begin
              tbl_q <= mem_rsp_data[PA_W-1:OFF_W];
              st    <= S_INNER;
            end
          end
        end
        S_INNER: begin
          if (rd_hs) issued <= 1'b1;
          if (rsp_in) begin
            issued <= 1'b0;
            if (!e_valid) begin
              fc_q <= FC_LEAF;
              st   <= S_FAULT;
            end else if (prot_bad) begin
              fc_q <= FC_PROT;
              st   <= S_FAULT;
            end else begin
              pa_q <= {mem_rsp_data[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
              st   <= S_DONE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R9
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !done && !fault && req_ready);

  // R3
  len_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ({1'b0, req_p1} >= pt_len)
      |=> fault && (fault_code == 3'd1) && !mem_rd_valid);

  // R8
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fault_code == 3'd0);
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [31:0] pt_base = 32'h0001_0000;
  logic [12:0] pt_len = 13'd16;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [31:0] paddr;
  logic [2:0]  fault_code;

  int checks = 0, fails = 0;
  logic [31:0] mem [logic [31:0]];
  int lat = 0;
  bit stall = 0;
  int nrd = 0;
  logic [31:0] rd_log [0:3];

  always #10 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .pt_base(pt_base), .pt_len(pt_len),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .paddr(paddr), .fault_code(fault_code));

  function automatic logic [31:0] pte(input logic [21:0] frm, input logic [3:0] fl);
    return {frm, 6'b0, fl};
  endfunction

  function automatic logic [31:0] mkva(input int d, input int t, input int off);
    return {d[11:0], t[9:0], off[9:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin : memory_model
    bit pend = 0;
    int cnt = 0;
    logic [31:0] a = '0;
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      mem_rsp_valid <= 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem.exists(a) ? mem[a] : 32'h0;
          pend = 0;
        end else cnt--;
      end
      if (mem_rd_valid && mem_rd_ready) begin
        a = mem_rd_addr;
        if (nrd < 4) rd_log[nrd] = a;
        nrd++;
        pend = 1;
        cnt = lat;
      end
      mem_rd_ready <= stall ? cyc[1] : 1'b1;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic walk(input string tag, input logic [31:0] va, input logic [1:0] k,
                      input logic [2:0] efc, input logic [31:0] epa, input int enr,
                      input logic [31:0] ea0, input logic [31:0] ea1);
    int n = 0;
    bit busy_ok = 1;
    nrd = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
    while (!(done || fault) && n < 300) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      n++;
    end
    chk(busy_ok && !req_ready, {tag, " R9 ready low during walk"}, {31'b0, req_ready}, 32'd0);
    chk(efc == 0 ? (done && !fault) : (fault && !done), {tag, " pulse kind"},
        {30'b0, done, fault}, efc == 0 ? 32'd2 : 32'd1);
    chk(fault_code == efc, {tag, " fault code"}, {29'b0, fault_code}, {29'b0, efc});
    if (efc == 0) chk(paddr == epa, {tag, " R8 physical address"}, paddr, epa);
    chk(nrd == enr, {tag, " read count"}, nrd, enr);
    if (enr > 0) chk(rd_log[0] == ea0, {tag, " R1 directory address"}, rd_log[0], ea0);
    if (enr > 1) chk(rd_log[1] == ea1, {tag, " R2 leaf address"}, rd_log[1], ea1);
    @(negedge clk);
    chk(!done && !fault && req_ready, {tag, " R9 pulse one cycle"},
        {29'b0, done, fault, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk(req_ready && !done && !fault && !mem_rd_valid, "R11 reset state",
        {28'b0, req_ready, done, fault, mem_rd_valid}, 32'h8);
  endtask

  task automatic t_read;
    lat = 0; stall = 0;
    walk("R1 R2 read", mkva(3, 5, 'h123), 2'd0, 3'd0, {22'h2AB, 10'h123}, 2, 32'h1000C, 32'h20014);
    walk("R1 read kind3", mkva(3, 5, 0), 2'd3, 3'd0, {22'h2AB, 10'h0}, 2, 32'h1000C, 32'h20014);
  endtask

  task automatic t_write;
    lat = 3; stall = 1;
    walk("R10 R6 write ok stalled", mkva(3, 6, 'h3FF), 2'd1, 3'd0, {22'h155, 10'h3FF}, 2, 32'h1000C, 32'h20018);
    lat = 1; stall = 0;
    walk("R6 write read-only", mkva(3, 5, 0), 2'd1, 3'd4, 0, 2, 32'h1000C, 32'h20014);
  endtask

  task automatic t_exec;
    lat = 0; stall = 1;
    walk("R7 exec ok", mkva(3, 7, 'h10), 2'd2, 3'd0, {22'h3F0, 10'h10}, 2, 32'h1000C, 32'h2001C);
    walk("R7 exec non-exec", mkva(3, 6, 'h10), 2'd2, 3'd4, 0, 2, 32'h1000C, 32'h20018);
    walk("R7 read exec-only", mkva(3, 8, 'h20), 2'd0, 3'd4, 0, 2, 32'h1000C, 32'h20020);
    walk("R7 write exec-only", mkva(3, 8, 'h20), 2'd1, 3'd4, 0, 2, 32'h1000C, 32'h20020);
    walk("R7 exec exec-only", mkva(3, 8, 'h20), 2'd2, 3'd0, {22'h0F1, 10'h20}, 2, 32'h1000C, 32'h20020);
    stall = 0;
  endtask

  task automatic t_len;
    walk("R3 index at bound", mkva(16, 0, 0), 2'd0, 3'd1, 0, 0, 0, 0);
    walk("R3 top index", mkva(4095, 1023, 0), 2'd0, 3'd1, 0, 0, 0, 0);
    walk("R4 last legal index invalid dir", mkva(15, 0, 0), 2'd0, 3'd2, 0, 1, 32'h1003C, 0);
    pt_len = 13'd0;
    walk("R3 zero length", mkva(0, 0, 0), 2'd0, 3'd1, 0, 0, 0, 0);
    pt_len = 13'd16;
  endtask

  task automatic t_leaf_invalid;
    lat = 2;
    walk("R5 leaf invalid", mkva(3, 9, 0), 2'd0, 3'd3, 0, 2, 32'h1000C, 32'h20024);
  endtask

  task automatic t_edge;
    lat = 5; stall = 1;
    walk("R8 R2 top frame and offset", mkva(0, 1023, 'h3FF), 2'd1, 3'd0, 32'hFFFF_FFFF, 2, 32'h10000, 32'h40FFC);
    stall = 0; lat = 0;
  endtask

  initial begin
    mem[32'h1000C] = pte(22'h80, 4'b0001);
    mem[32'h10000] = pte(22'h100, 4'b0001);
    mem[32'h20014] = pte(22'h2AB, 4'b0001);
    mem[32'h20018] = pte(22'h155, 4'b0011);
    mem[32'h2001C] = pte(22'h3F0, 4'b0101);
    mem[32'h20020] = pte(22'h0F1, 4'b1101);
    mem[32'h40FFC] = pte(22'h3FFFFF, 4'b0011);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_exec();
    t_len();
    t_leaf_invalid();
    t_edge();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule